// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block accepts a wide instruction word made of two equal slots (left = upper half, right = lower half) and controls how the slots go to the execution units. Two format bits select one of four modes: a parallel pair, a left-then-right sequence, a right-then-left sequence, or a single long instruction. The block presents one issue at a time on a single issue channel. The channel carries the instruction bits, a unit tag and the current address, and it stays up until the execution side returns a result for that issue.

Each result reports whether the slot branched, its branch target, and a kill-right indication. The block uses these results to decide whether a second slot issues. It then merges the per-slot outcomes into one registered next-address result with a separate valid bit. In parallel mode, two branches at once raise an error. The block also emits pulses that tell the surrounding pipeline when to commit pending register writes and when to clear the per-dispatch side flags.

Top module: `vliw_dispatch`

## Requirements
- R1: The mode is {word_i[0], word_i[SLOT_W]}. Code 0 is parallel, 1 is left-then-right, 2 is right-then-left and 3 is long. The left slot is word_i[2*SLOT_W-1:SLOT_W] and the right slot is word_i[SLOT_W-1:0]. A slot appears on iss_data_o zero-extended.
- R2: In parallel mode the first issue is the left slot with unit tag 0 (memory) and the second is the right slot with unit tag 1 (integer). Both issues carry the latched address. The second issue always happens.
- R3: Left-then-right issues the left slot on unit 0 and then the right slot on unit 2 (any). Right-then-left issues the right slot on unit 1 and then the left slot on unit 2.
- R4: Long mode makes exactly one issue. That issue carries the full word on unit 2 with iss_long_o=1. iss_long_o is 0 for every other issue.
- R5: In a sequential mode the second slot issues only if the first result has neither res_br_i nor res_kill_i set. Otherwise the dispatch completes right after the first result.
- R6: In a sequential mode or long mode, the next-address result is that of the last slot issued. Kill from a parallel slot, from a second slot or from a long instruction has no effect.
- R7: In parallel mode, if no slot branches the result is invalid. If exactly one slot branches, its target is the result. If both branch, err_o=1 and nxt_vld_o=0. err_o is 0 in all other cases.
- R8: commit_o pulses in the cycle each sequential or long result is accepted. In parallel mode it pulses only when the second result is accepted.
- R9: flag_clr_o is high in the cycle a start is accepted and in the done cycle.
- R10: done_o is high for exactly one cycle, one cycle after the final result is accepted. nxt_vld_o, nxt_addr_o and err_o are valid from then and hold until the next completion. start_i has no effect while a dispatch is in progress.
- R11: iss_vld_o stays high with stable data and unit until res_vld_i is seen.
- R12: After reset no issue, commit, done, valid result or error is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a dispatch (taken when idle) |
| word_i | input | 2*SLOT_W | Instruction word |
| cur_addr_i | input | ADDR_W | Address of the instruction word |
| iss_vld_o | output | 1 | Issue request active |
| iss_data_o | output | 2*SLOT_W | Slot bits, or full word in long mode |
| iss_unit_o | output | 2 | Unit tag: 0 memory, 1 integer, 2 any |
| iss_long_o | output | 1 | Issue is a long instruction |
| iss_addr_o | output | ADDR_W | Current address for the issue |
| res_vld_i | input | 1 | Result for the present issue |
| res_br_i | input | 1 | Slot branched |
| res_tgt_i | input | ADDR_W | Branch target |
| res_kill_i | input | 1 | Slot suppresses the following slot |
| commit_o | output | 1 | Commit pending register writes |
| flag_clr_o | output | 1 | Clear per-dispatch side flags |
| done_o | output | 1 | Dispatch complete pulse |
| nxt_vld_o | output | 1 | Next-address result is a branch |
| nxt_addr_o | output | ADDR_W | Next-address target |
| err_o | output | 1 | Both parallel slots branched |

## Verification
The bench builds the block with SLOT_W=16 and ADDR_W=16. With these sizes every mode can be swept against all sixteen combinations of first and second branch and kill, each at result latencies of zero and one wait cycle. The narrow slots let each case use distinct slot and target patterns, so a swapped slot, a wrong unit tag or a wrong merge target shows up at once. The wait cycles carry stray start pulses, which covers the hold behaviour and the rule that start is ignored while busy.

// File: rtl/vd_pkg.sv
package vd_pkg;
  typedef enum logic [1:0] {
    MODE_PAR  = 2'd0,
    MODE_LR   = 2'd1,
    MODE_RL   = 2'd2,
    MODE_LONG = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    UNIT_MEM = 2'd0,
    UNIT_INT = 2'd1,
    UNIT_ANY = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ISS1 = 2'd1,
    ST_ISS2 = 2'd2,
    ST_DONE = 2'd3
  } state_e;
endpackage

// File: rtl/vd_decode.sv
module vd_decode
  import vd_pkg::*;
#(
  parameter int SLOT_W = 32,
  localparam int WORD_W = 2 * SLOT_W
) (
  input  logic [WORD_W-1:0] word_i,
  output mode_e             mode_o,
  output logic [WORD_W-1:0] data1_o,
  output logic [WORD_W-1:0] data2_o,
  output unit_e             unit1_o,
  output unit_e             unit2_o,
  output logic              seq_o
);
  logic [WORD_W-1:0] left_ext, right_ext;

  assign left_ext  = {{SLOT_W{1'b0}}, word_i[WORD_W-1:SLOT_W]};
  assign right_ext = {{SLOT_W{1'b0}}, word_i[SLOT_W-1:0]};
  assign mode_o    = mode_e'({word_i[0], word_i[SLOT_W]});
  assign seq_o     = (mode_o == MODE_LR) || (mode_o == MODE_RL);

  always_comb begin
    data1_o = word_i;
    data2_o = word_i;
    unit1_o = UNIT_ANY;
    unit2_o = UNIT_ANY;
    unique case (mode_o)
      MODE_PAR: begin
        data1_o = left_ext;  unit1_o = UNIT_MEM;
        data2_o = right_ext; unit2_o = UNIT_INT;
      end
      MODE_LR: begin
        data1_o = left_ext;  unit1_o = UNIT_MEM;
        data2_o = right_ext; unit2_o = UNIT_ANY;
      end
      MODE_RL: begin
        data1_o = right_ext; unit1_o = UNIT_INT;
        data2_o = left_ext;  unit2_o = UNIT_ANY;
      end
      default: begin
        data1_o = word_i;    unit1_o = UNIT_ANY;
        data2_o = word_i;    unit2_o = UNIT_ANY;
      end
    endcase
  end
endmodule

// File: rtl/vd_merge.sv
module vd_merge #(
  parameter int ADDR_W = 32
) (
  input  logic              par_i,
  input  logic              two_i,
  input  logic              a_br_i,
  input  logic [ADDR_W-1:0] a_tgt_i,
  input  logic              b_br_i,
  input  logic [ADDR_W-1:0] b_tgt_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              err_o
);
  always_comb begin
    err_o = 1'b0;
    vld_o = a_br_i;
    tgt_o = a_tgt_i;
    if (two_i && !par_i) begin
      vld_o = b_br_i;
      tgt_o = b_tgt_i;
    end else if (two_i) begin
      err_o = a_br_i && b_br_i;
      vld_o = a_br_i ^ b_br_i;
      tgt_o = a_br_i ? a_tgt_i : b_tgt_i;
    end
  end
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import vd_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int ADDR_W = 32,
  localparam int WORD_W = 2 * SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              iss_vld_o,
  output logic [WORD_W-1:0] iss_data_o,
  output logic [1:0]        iss_unit_o,
  output logic              iss_long_o,
  output logic [ADDR_W-1:0] iss_addr_o,
  input  logic              res_vld_i,
  input  logic              res_br_i,
  input  logic [ADDR_W-1:0] res_tgt_i,
  input  logic              res_kill_i,
  output logic              commit_o,
  output logic              flag_clr_o,
  output logic              done_o,
  output logic              nxt_vld_o,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic              err_o
);
  state_e            st_q, st_d;
  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] addr_q, tgt1_q;
  logic              br1_q;

  mode_e             mode;
  logic [WORD_W-1:0] data1, data2;
  unit_e             unit1, unit2;
  logic              seq, accept, go2, finish;
  logic              m_vld, m_err;
  logic [ADDR_W-1:0] m_tgt;

  vd_decode #(.SLOT_W(SLOT_W)) u_dec (
    .word_i (word_q),
    .mode_o (mode),
    .data1_o(data1),
    .data2_o(data2),
    .unit1_o(unit1),
    .unit2_o(unit2),
    .seq_o  (seq)
  );

  // first operand: live result in ISS1, captured first result in ISS2
  vd_merge #(.ADDR_W(ADDR_W)) u_merge (
    .par_i  (mode == MODE_PAR),
    .two_i  (st_q == ST_ISS2),
    .a_br_i (st_q == ST_ISS1 ? res_br_i  : br1_q),
    .a_tgt_i(st_q == ST_ISS1 ? res_tgt_i : tgt1_q),
    .b_br_i (res_br_i),
    .b_tgt_i(res_tgt_i),
    .vld_o  (m_vld),
    .tgt_o  (m_tgt),
    .err_o  (m_err)
  );

  assign accept = res_vld_i && (st_q == ST_ISS1 || st_q == ST_ISS2);
  assign go2    = (mode == MODE_PAR) || (seq && !res_br_i && !res_kill_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_ISS1;
      ST_ISS1: if (res_vld_i) st_d = go2 ? ST_ISS2 : ST_DONE;
      ST_ISS2: if (res_vld_i) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign finish = accept && (st_d == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      word_q     <= '0;
      addr_q     <= '0;
      br1_q      <= 1'b0;
      tgt1_q     <= '0;
      nxt_vld_o  <= 1'b0;
      nxt_addr_o <= '0;
      err_o      <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        word_q <= word_i;
        addr_q <= cur_addr_i;
      end
      if (st_q == ST_ISS1 && res_vld_i) begin
        br1_q  <= res_br_i;
        tgt1_q <= res_tgt_i;
      end
      if (finish) begin
        nxt_vld_o  <= m_vld;
        nxt_addr_o <= m_tgt;
        err_o      <= m_err;
      end
    end
  end

  assign iss_vld_o  = (st_q == ST_ISS1) || (st_q == ST_ISS2);
  assign iss_data_o = (st_q == ST_ISS2) ? data2 : data1;
  assign iss_unit_o = (st_q == ST_ISS2) ? unit2 : unit1;
  assign iss_long_o = (st_q == ST_ISS1) && (mode == MODE_LONG);
  assign iss_addr_o = addr_q;
  assign commit_o   = accept && ((st_q == ST_ISS2) || (mode != MODE_PAR));
  assign flag_clr_o = (st_q == ST_IDLE && start_i) || (st_q == ST_DONE);
  assign done_o     = (st_q == ST_DONE);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_issue_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_o && !res_vld_i) |=> (iss_vld_o && $stable(iss_data_o) && $stable(iss_unit_o)));

  assert_seq_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ISS1 && res_vld_i && seq && (res_br_i || res_kill_i)) |=> done_o);

  assert_par_second_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ISS1 && res_vld_i && mode == MODE_PAR) |=> (iss_vld_o && iss_unit_o == UNIT_INT));

  assert_err_par_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (mode == MODE_PAR && !nxt_vld_o));

  assert_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (iss_vld_o && res_vld_i));
endmodule

// File: tb/vliw_dispatch_tb.sv
module vliw_dispatch_tb;
  localparam int SW = 16;
  localparam int AW = 16;
  localparam int WW = 2 * SW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [WW-1:0] word_i = '0;
  logic [AW-1:0] cur_addr_i = '0;
  logic          iss_vld_o, iss_long_o, commit_o, flag_clr_o, done_o, nxt_vld_o, err_o;
  logic [WW-1:0] iss_data_o;
  logic [1:0]    iss_unit_o;
  logic [AW-1:0] iss_addr_o, nxt_addr_o;
  logic          res_vld_i = 1'b0, res_br_i = 1'b0, res_kill_i = 1'b0;
  logic [AW-1:0] res_tgt_i = '0;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  vliw_dispatch #(.SLOT_W(SW), .ADDR_W(AW)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [1:0] m, input bit b1, input bit k1, input bit b2,
                          input bit k2, input int lat, input int n);
    logic [SW-1:0] left, right;
    logic [WW-1:0] w, ed;
    logic [AW-1:0] a, t1, t2, et;
    logic [1:0]    eu;
    bit            two, ev, ee;
    left     = 16'h5a00 + SW'(n * 3);
    right    = 16'h3c00 ^ SW'(n);
    left[0]  = m[0];
    right[0] = m[1];
    w  = {left, right};
    a  = 16'h0100 + AW'(n * 8);
    t1 = 16'h8000 + AW'(n);
    t2 = 16'h4000 + AW'(n);
    two = (m == 2'd0) || ((m == 2'd1 || m == 2'd2) && !b1 && !k1);

    @(negedge clk_i);
    start_i = 1'b1; word_i = w; cur_addr_i = a;
    #1 check(flag_clr_o == 1'b1, "R9 start clear", flag_clr_o, 1);
    @(negedge clk_i);
    start_i = 1'b0; word_i = '0; cur_addr_i = '0;

    for (int s = 0; s < (two ? 2 : 1); s++) begin
      if (m == 2'd3)      begin ed = w; eu = 2'd2; end
      else if (s == 0)    begin
        ed = (m == 2'd2) ? {16'h0, right} : {16'h0, left};
        eu = (m == 2'd2) ? 2'd1 : 2'd0;
      end else begin
        ed = (m == 2'd2) ? {16'h0, left} : {16'h0, right};
        eu = (m == 2'd0) ? 2'd1 : 2'd2;
      end
      for (int l = 0; l < lat; l++) begin
        start_i = 1'b1; word_i = ~w;
        #1 check(iss_vld_o == 1'b1 && iss_data_o == ed, "R11 hold/R10 start ignored",
                 iss_data_o, ed);
        @(negedge clk_i);
        start_i = 1'b0; word_i = '0;
      end
      #1;
      check(iss_vld_o == 1'b1, "R5 issue present", iss_vld_o, 1);
      check(iss_data_o == ed, "R1 slot data", iss_data_o, ed);
      check(iss_unit_o == eu, m == 2'd3 ? "R4 unit" : (m == 2'd0 ? "R2 unit" : "R3 unit"),
            iss_unit_o, eu);
      check(iss_long_o == (m == 2'd3 && s == 0), "R4 long flag", iss_long_o, m == 2'd3);
      check(iss_addr_o == a, "R2 issue address", iss_addr_o, a);
      res_vld_i = 1'b1;
      res_br_i   = s ? b2 : b1;
      res_tgt_i  = s ? t2 : t1;
      res_kill_i = s ? k2 : k1;
      #1 check(commit_o == (m != 2'd0 || s == 1), "R8 commit", commit_o, (m != 2'd0 || s == 1));
      @(negedge clk_i);
      res_vld_i = 1'b0; res_br_i = 1'b0; res_kill_i = 1'b0; res_tgt_i = '0;
    end

    if (m == 2'd0) begin
      ee = b1 && b2; ev = b1 ^ b2; et = b1 ? t1 : t2;
    end else if (two) begin
      ee = 1'b0; ev = b2; et = t2;
    end else begin
      ee = 1'b0; ev = b1; et = t1;
    end
    #1;
    check(done_o == 1'b1 && iss_vld_o == 1'b0, "R5 R10 done after last slot", done_o, 1);
    check(flag_clr_o == 1'b1, "R9 done clear", flag_clr_o, 1);
    check(err_o == ee, "R7 error", err_o, ee);
    check(nxt_vld_o == ev, m == 2'd0 ? "R7 valid" : "R6 valid", nxt_vld_o, ev);
    if (ev) check(nxt_addr_o == et, m == 2'd0 ? "R7 target" : "R6 target", nxt_addr_o, et);
    @(negedge clk_i);
    #1;
    check(done_o == 1'b0, "R10 done one cycle", done_o, 0);
    check(nxt_vld_o == ev && err_o == ee, "R10 result held", nxt_vld_o, ev);
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    #35;
    check(iss_vld_o == 0 && commit_o == 0 && done_o == 0, "R12 reset outputs", iss_vld_o, 0);
    check(nxt_vld_o == 0 && err_o == 0, "R12 reset result", {nxt_vld_o, err_o}, 0);
    rst_ni = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 16; c++)
        for (int lat = 0; lat < 2; lat++) begin
          run_case(2'(m), c[3], c[2], c[1], c[0], lat, n);
          n++;
        end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule